// File: doc/BRIEF.md
# Link Trace Capture Front-End

This block sits behind the receivers of a narrow, source-synchronous link that has eight data lanes and one framing-strobe lane, and it records the link's traffic for later offline study. The link clock is the block clock. Every lane is sampled on both of its edges, so each clock cycle yields two beats. The block undoes the polarity swaps and the lane reordering of the board wiring, groups four beats into a 32-bit word, and forms a second copy of that word that starts at the beat carrying the strobe. All-zero words are thrown away. Every word that is kept is stamped with the number of clock cycles since capture started.

Capture starts only after a trigger input has been held high long enough. Short runt pulses are rejected, and once capture is running, further trigger activity has no effect until the block is re-armed. Records go into a small FIFO that a consumer drains through a show-ahead valid/pop interface. A full FIFO loses new records and raises a sticky flag, and the cycle stamp keeps counting, so the gap can be seen.

The trigger qualifier is a three-state machine. `TRG_IDLE` waits for the trigger. `TRG_QUAL` counts how many consecutive cycles the trigger has been high. `TRG_RUN` is capturing. The transitions are:
- idle to qual: trigger high, but the hold count has not yet been met.
- idle to run: trigger high, and a hold of 0 or 1 is set.
- qual to idle: runt, meaning the trigger fell early.
- qual to run: the hold count has been reached.
- run to idle: re-arm.

Top module: `tcap_front`

## Requirements
- R1: Physical lanes 1, 2, 3, 4, 5, 7 and 8 are inverted on entry, and physical lanes 0 and 6 are taken as-is. A physical lane is a position in `link_pins`. The link therefore idles at logical zero.
- R2: The logical bits are taken from these physical lanes: data bit 0 from 2, bit 1 from 8, bit 2 from 4, bit 3 from 5, bit 4 from 1, bit 5 from 6, bit 6 from 7, bit 7 from 3, and the strobe (logical bit 8) from 0.
- R3: In each clock cycle, the beat sampled on the falling edge comes first and the beat sampled on the following rising edge comes second. Counting from reset release, every four beats form an unaligned group. The first beat of a group goes in bits 7:0 and the last in bits 31:24, and this group appears in `rd_raw`.
- R4: The tag has bit p set, where p is the lowest beat position (0 is the oldest) in the unaligned group whose strobe is high. The aligned word `rd_data` is then the four beats starting at position p. If no beat in the group has a strobe, the tag is 0000 and the aligned word equals the unaligned word.
- R5: An aligned word equal to 0x00000000 produces no record.
- R6: Capture starts only after `trig_in` has been high for `min_hold` consecutive clock cycles. A shorter pulse leaves capture off.
- R7: While capture is on, `trig_in` is ignored. A `rearm` pulse turns capture off in the next cycle.
- R8: The cycle stamp is 0 in the first capturing cycle and rises by one every clock while capture stays on. Each record carries the stamp of the cycle in which its word completed.
- R9: No record is stored while capture is off.
- R10: When the FIFO is full, a new record is dropped and `overflow` becomes 1. It stays 1 until a `rearm` arrives, and the stamp keeps counting.
- R11: `rd_valid` is high whenever the FIFO holds a record, and the `rd_*` fields show the oldest record. `rd_pop` while `rd_valid` is high removes that record at the clock edge.
- R12: After reset, capture is off, `overflow` is 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; both edges sample the lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_pins | input | 9 | Physical lanes after level conversion, in board order |
| trig_in | input | 1 | Capture trigger, synchronous to clk |
| rearm | input | 1 | Stops capture, clears overflow, and waits for a new trigger |
| min_hold | input | 16 | Cycles the trigger must stay high to start capture |
| capture_on | output | 1 | High while capture is running |
| overflow | output | 1 | Sticky flag: a record was lost to a full FIFO |
| rd_pop | input | 1 | Removes the oldest record when rd_valid is high |
| rd_valid | output | 1 | FIFO holds at least one record |
| rd_seq | output | 24 | Cycle stamp of the oldest record |
| rd_data | output | 32 | Strobe-aligned word of the oldest record |
| rd_tag | output | 4 | Strobe beat position of the oldest record |
| rd_raw | output | 32 | Unaligned word of the oldest record |

## Verification
The bench models the link and compares against the design on every clock, so a wrong lane-map or polarity entry shows up as a wrong `rd_data` or `rd_raw` on the first non-idle record. A slipped beat phase corrupts both words and the tag two to three cycles after the disturbing beat. A trigger qualifier in the wrong state shows at once on `capture_on`. A stamp counter that is off by one, or that stops during overflow, shows in `rd_seq` of the next record popped after the gap. A misbehaving FIFO count shows as an `rd_valid` mismatch or a missing `overflow` within the cycle of the faulty write.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        TRG_IDLE = 2'd0,
        TRG_QUAL = 2'd1,
        TRG_RUN  = 2'd2
    } trg_state_e;

endpackage

// File: rtl/tcap_ddr_in.sv
module tcap_ddr_in #(
    parameter int                       LANES    = 9,
    parameter int                       MAP_W    = 4,
    parameter logic [LANES*MAP_W-1:0]   LANE_MAP = 36'h037615482,
    parameter logic [LANES-1:0]         LANE_INV = 9'h1BE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pins,
    output logic [LANES-1:0] beat_early,
    output logic [LANES-1:0] beat_late
);

    logic [LANES-1:0]   fall_q;
    logic [2*LANES-1:0] pair_q;
    logic [LANES-1:0]   fixed [2];

    // falling edge holds the first beat of the cycle
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= LANE_INV;
        else        fall_q <= pins;
    end

    // rising edge closes the pair: second beat high, first beat low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= {LANE_INV, LANE_INV};
        else        pair_q <= {pins, fall_q};
    end

    for (genvar b = 0; b < 2; b++) begin : g_beat
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int SRC = int'(LANE_MAP[l*MAP_W +: MAP_W]);
            assign fixed[b][l] = pair_q[b*LANES + SRC] ^ LANE_INV[SRC];
        end
    end

    assign beat_early = fixed[0];
    assign beat_late  = fixed[1];

endmodule

// File: rtl/tcap_aligner.sv
module tcap_aligner #(
    parameter int LANES      = 9,
    parameter int WORD_BEATS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LANES-1:0]                  beat_early,
    input  logic [LANES-1:0]                  beat_late,
    output logic                              word_ok,
    output logic [(LANES-1)*WORD_BEATS-1:0]   word_data,
    output logic [WORD_BEATS-1:0]             word_tag,
    output logic [(LANES-1)*WORD_BEATS-1:0]   word_raw
);

    localparam int DW     = LANES - 1;
    localparam int STB    = LANES - 1;
    localparam int HIST   = 2 * WORD_BEATS;
    localparam int CYC    = WORD_BEATS / 2;
    localparam int PH_W   = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC - 1);

    logic [LANES-1:0]      hist_q [HIST];
    logic [PH_W-1:0]       ph_q;
    logic [WORD_BEATS-1:0] stb_vec;
    logic                  hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
        end else begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            for (int i = 0; i < HIST - 2; i++) hist_q[i] <= hist_q[i+2];
            hist_q[HIST-2] <= beat_early;
            hist_q[HIST-1] <= beat_late;
        end
    end

    always_comb begin
        for (int p = 0; p < WORD_BEATS; p++) stb_vec[p] = hist_q[p][STB];
    end

    assign hit      = |stb_vec;
    assign word_tag = stb_vec & (~stb_vec + 1'b1);

    always_comb begin
        word_data = '0;
        word_raw  = '0;
        for (int b = 0; b < WORD_BEATS; b++) word_raw[b*DW +: DW] = hist_q[b][DW-1:0];
        for (int p = 0; p < WORD_BEATS; p++) begin
            if (hit ? word_tag[p] : (p == 0)) begin
                for (int b = 0; b < WORD_BEATS; b++)
                    word_data[b*DW +: DW] = hist_q[p+b][DW-1:0];
            end
        end
    end

    assign word_ok = (ph_q == PH_LAST) && (word_data != '0);

endmodule

// File: rtl/tcap_trig_fsm.sv
module tcap_trig_fsm
    import tcap_pkg::*;
#(
    parameter int SEQ_W  = 24,
    parameter int QCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              rearm,
    input  logic [QCNT_W-1:0] min_len,
    output logic              running,
    output logic [SEQ_W-1:0]  seq
);

    trg_state_e        state_q, state_d;
    logic [QCNT_W-1:0] qcnt_q, qcnt_inc;
    logic [SEQ_W-1:0]  seq_q;
    logic              held;

    assign qcnt_inc = (state_q == TRG_QUAL) ? qcnt_q + 1'b1 : QCNT_W'(1);
    assign held     = qcnt_inc >= min_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE: if (trig) state_d = held ? TRG_RUN : TRG_QUAL;
            TRG_QUAL: begin
                if (!trig)     state_d = TRG_IDLE;
                else if (held) state_d = TRG_RUN;
            end
            TRG_RUN:  if (rearm) state_d = TRG_IDLE;
            default:  state_d = TRG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt_q <= '0;
            seq_q  <= '0;
        end else begin
            qcnt_q <= (state_d == TRG_QUAL) ? qcnt_inc : '0;
            if (state_d == TRG_RUN)
                seq_q <= (state_q == TRG_RUN) ? seq_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        running = (state_q == TRG_RUN);
        seq     = seq_q;
    end

endmodule

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
    parameter int W     = 92,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_rec,
    input  logic         rd_pop,
    output logic         rd_valid,
    output logic [W-1:0] rd_rec,
    input  logic         ovf_clr,
    output logic         ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, do_wr, do_rd;

    assign full  = (count == CNT_FULL);
    assign do_wr = wr_req && !full;
    assign do_rd = rd_pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_rec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + {{AW{1'b0}}, do_wr} - {{AW{1'b0}}, do_rd};
            if (wr_req && full) ovf <= 1'b1;
            else if (ovf_clr)   ovf <= 1'b0;
        end
    end

    assign rd_valid = (count != '0);
    assign rd_rec   = mem[rd_ptr];

endmodule

// File: rtl/tcap_front.sv
module tcap_front #(
    parameter int                     LANES      = 9,
    parameter int                     WORD_BEATS = 4,
    parameter int                     SEQ_W      = 24,
    parameter int                     QCNT_W     = 16,
    parameter int                     FIFO_DEPTH = 8,
    parameter int                     MAP_W      = 4,
    parameter logic [LANES*MAP_W-1:0] LANE_MAP   = 36'h037615482,
    parameter logic [LANES-1:0]       LANE_INV   = 9'h1BE
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [LANES-1:0]                    link_pins,
    input  logic                                trig_in,
    input  logic                                rearm,
    input  logic [QCNT_W-1:0]                   min_hold,
    output logic                                capture_on,
    output logic                                overflow,
    input  logic                                rd_pop,
    output logic                                rd_valid,
    output logic [SEQ_W-1:0]                    rd_seq,
    output logic [(LANES-1)*WORD_BEATS-1:0]     rd_data,
    output logic [WORD_BEATS-1:0]               rd_tag,
    output logic [(LANES-1)*WORD_BEATS-1:0]     rd_raw
);

    localparam int WORD_W = (LANES - 1) * WORD_BEATS;
    localparam int REC_W  = SEQ_W + 2 * WORD_W + WORD_BEATS;

    logic [LANES-1:0]      beat_early, beat_late;
    logic                  word_ok;
    logic [WORD_W-1:0]     word_data, word_raw;
    logic [WORD_BEATS-1:0] word_tag;
    logic [SEQ_W-1:0]      seq_now;
    logic [REC_W-1:0]      rec_in, rec_out;

    tcap_ddr_in #(
        .LANES(LANES), .MAP_W(MAP_W), .LANE_MAP(LANE_MAP), .LANE_INV(LANE_INV)
    ) u_ddr (
        .clk(clk), .rst_n(rst_n), .pins(link_pins),
        .beat_early(beat_early), .beat_late(beat_late)
    );

    tcap_aligner #(.LANES(LANES), .WORD_BEATS(WORD_BEATS)) u_align (
        .clk(clk), .rst_n(rst_n),
        .beat_early(beat_early), .beat_late(beat_late),
        .word_ok(word_ok), .word_data(word_data),
        .word_tag(word_tag), .word_raw(word_raw)
    );

    tcap_trig_fsm #(.SEQ_W(SEQ_W), .QCNT_W(QCNT_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig(trig_in), .rearm(rearm),
        .min_len(min_hold), .running(capture_on), .seq(seq_now)
    );

    assign rec_in = {seq_now, word_data, word_tag, word_raw};

    tcap_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_req(word_ok && capture_on), .wr_rec(rec_in),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_rec(rec_out),
        .ovf_clr(rearm), .ovf(overflow)
    );

    assign {rd_seq, rd_data, rd_tag, rd_raw} = rec_out;

endmodule

// File: rtl/tcap_front_chk.sv
module tcap_front_chk #(
    parameter int SEQ_W      = 24,
    parameter int WORD_W     = 32,
    parameter int WORD_BEATS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  trig_in,
    input logic                  rearm,
    input logic                  capture_on,
    input logic                  overflow,
    input logic                  rd_valid,
    input logic [WORD_W-1:0]     rd_data,
    input logic [WORD_BEATS-1:0] rd_tag,
    input logic [SEQ_W-1:0]      seq_now
);

    p_tag_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $onehot0(rd_tag));

    p_no_idle_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data != '0));

    p_start_needs_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture_on) |-> $past(trig_in));

    p_rearm_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_on && rearm) |=> !capture_on);

    p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_on && $past(capture_on)) |-> (seq_now == SEQ_W'($past(seq_now) + 1'b1)));

    p_no_rec_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_on |=> !$rose(rd_valid));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rearm) |=> overflow);

endmodule

bind tcap_front tcap_front_chk #(
    .SEQ_W(SEQ_W), .WORD_W((LANES-1)*WORD_BEATS), .WORD_BEATS(WORD_BEATS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rearm(rearm),
    .capture_on(capture_on), .overflow(overflow), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_tag(rd_tag), .seq_now(seq_now)
);

// File: tb/tcap_front_bench.sv
`timescale 1ns/1ps
module tcap_front_bench;

    localparam int DEPTH = 8;
    localparam int MINH  = 5;
    localparam int MAPB [9] = '{2, 8, 4, 5, 1, 6, 7, 3, 0};
    localparam logic [8:0] INVB = 9'h1BE;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  link_pins;
    logic        trig_in, rearm, rd_pop;
    logic [15:0] min_hold;
    logic        capture_on, overflow, rd_valid;
    logic [23:0] rd_seq;
    logic [31:0] rd_data, rd_raw;
    logic [3:0]  rd_tag;

    always #2 clk = ~clk;

    tcap_front u_tcap_front (
        .clk(clk), .rst_n(rst_n), .link_pins(link_pins), .trig_in(trig_in),
        .rearm(rearm), .min_hold(min_hold), .capture_on(capture_on),
        .overflow(overflow), .rd_pop(rd_pop), .rd_valid(rd_valid),
        .rd_seq(rd_seq), .rd_data(rd_data), .rd_tag(rd_tag), .rd_raw(rd_raw)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_state = 0;
    int          m_qcnt = 0;
    logic [23:0] m_seq = '0;
    logic [8:0]  m_mp [2] = '{default: '0};
    logic [8:0]  m_mh [8] = '{default: '0};
    int          m_ph = 0;
    bit          m_ovf = 0;
    logic [23:0] q_seq [$];
    logic [31:0] q_data [$];
    logic [3:0]  q_tag [$];
    logic [31:0] q_raw [$];

    logic [31:0] lcg = 32'h1234_5678;
    int          gb = 0;

    task automatic check(input string lbl, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", lbl, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] to_phys(input logic [8:0] lg);
        logic [8:0] ph = '0;
        for (int j = 0; j < 9; j++) ph[MAPB[j]] = lg[j] ^ INVB[MAPB[j]];
        return ph;
    endfunction

    function automatic logic [7:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[23:16];
    endfunction

    // mode 0 idle, 1 strobe every 4th beat at offset, 2 data no strobe, 3 mixed
    function automatic logic [8:0] gen(input int mode, input int off);
        logic [8:0] b;
        logic [7:0] d = rnd();
        case (mode)
            1:       b = {(gb % 4) == off, d};
            2:       b = {1'b0, d};
            3:       b = {lcg[27], (lcg[5:4] == 2'b00) ? 8'h00 : d};
            default: b = '0;
        endcase
        gb++;
        return b;
    endfunction

    task automatic model_edge(input logic [8:0] b0, input logic [8:0] b1,
                              input logic tg, input logic ra, input logic pp);
        bit wr = 0, ovf_set = 0;
        int p = -1;
        logic [31:0] d = '0, r = '0;
        logic [3:0]  t = '0;
        int n;
        if (m_state == 2 && m_ph == 1) begin
            for (int i = 3; i >= 0; i--) if (m_mh[i][8]) p = i;
            if (p >= 0) t[p] = 1'b1; else p = 0;
            for (int b = 0; b < 4; b++) begin
                d[b*8 +: 8] = m_mh[p+b][7:0];
                r[b*8 +: 8] = m_mh[b][7:0];
            end
            if (d != 0) begin
                if (q_data.size() == DEPTH) ovf_set = 1; else wr = 1;
            end
        end
        if (pp && q_data.size() > 0) begin
            void'(q_seq.pop_front()); void'(q_data.pop_front());
            void'(q_tag.pop_front()); void'(q_raw.pop_front());
        end
        if (wr) begin
            q_seq.push_back(m_seq); q_data.push_back(d);
            q_tag.push_back(t);     q_raw.push_back(r);
        end
        if (ovf_set) m_ovf = 1; else if (ra) m_ovf = 0;
        if (m_state == 2) begin
            if (ra) m_state = 0; else m_seq = m_seq + 24'd1;
        end else if (tg) begin
            n = (m_state == 1) ? m_qcnt + 1 : 1;
            if (n >= MINH) begin m_state = 2; m_seq = '0; m_qcnt = 0; end
            else begin m_state = 1; m_qcnt = n; end
        end else begin
            m_state = 0; m_qcnt = 0;
        end
        for (int i = 0; i < 6; i++) m_mh[i] = m_mh[i+2];
        m_mh[6] = m_mp[0]; m_mh[7] = m_mp[1];
        m_mp[0] = b0; m_mp[1] = b1;
        m_ph ^= 1;
    endtask

    task automatic step(input logic [8:0] b0, input logic [8:0] b1,
                        input logic tg, input logic ra, input logic pp);
        #0.5;
        link_pins = to_phys(b0); trig_in = tg; rearm = ra; rd_pop = pp;
        #1;
        check("R6 R7 capture state", 64'(capture_on), 64'(m_state == 2));
        check("R10 overflow flag", 64'(overflow), 64'(m_ovf));
        check("R11 rd_valid", 64'(rd_valid), 64'(q_data.size() > 0));
        if (rd_valid && q_data.size() > 0) begin
            check("R1 R2 R3 aligned data", 64'(rd_data), 64'(q_data[0]));
            check("R4 strobe tag", 64'(rd_tag), 64'(q_tag[0]));
            check("R8 cycle stamp", 64'(rd_seq), 64'(q_seq[0]));
            check("R3 unaligned raw", 64'(rd_raw), 64'(q_raw[0]));
        end
        #1;
        link_pins = to_phys(b1);
        @(posedge clk);
        model_edge(b0, b1, tg, ra, pp);
    endtask

    task automatic run_seg(input int n, input int mode, input int off,
                           input logic tg, input logic ra, input logic pp);
        for (int c = 0; c < n; c++) begin
            logic [8:0] b0 = gen(mode, off);
            logic [8:0] b1 = gen(mode, off);
            step(b0, b1, tg, ra, pp);
        end
    endtask

    initial begin
        rst_n = 1'b0; link_pins = to_phys(9'h000);
        trig_in = 1'b0; rearm = 1'b0; rd_pop = 1'b0; min_hold = 16'(MINH);
        repeat (3) @(posedge clk);
        #0.2 rst_n = 1'b1;
        #0.3;
        check("R12 reset capture_on", 64'(capture_on), 64'd0);
        check("R12 reset overflow", 64'(overflow), 64'd0);
        check("R12 reset rd_valid", 64'(rd_valid), 64'd0);

        run_seg(4, 0, 0, 0, 0, 0);
        run_seg(10, 1, 1, 0, 0, 0);          // R9: traffic with capture off
        #0.3 check("R9 nothing stored while off", 64'(rd_valid), 64'd0);
        run_seg(3, 1, 1, 1, 0, 0);           // runt pulse
        run_seg(5, 1, 1, 0, 0, 0);
        #0.3 check("R6 runt rejected", 64'(capture_on), 64'd0);
        run_seg(6, 0, 0, 1, 0, 0);           // qualified trigger
        #0.3 check("R6 capture started", 64'(capture_on), 64'd1);

        run_seg(40, 1, 0, 0, 0, 1);
        run_seg(40, 1, 1, 0, 0, 1);
        run_seg(10, 1, 3, 1, 0, 1);          // R7: trigger ignored while on
        #0.3 check("R7 trigger ignored", 64'(capture_on), 64'd1);
        run_seg(40, 1, 3, 0, 0, 1);
        run_seg(40, 2, 0, 0, 0, 1);
        run_seg(20, 0, 0, 0, 0, 1);
        #0.3 check("R5 idle words dropped", 64'(rd_valid), 64'd0);
        run_seg(60, 3, 0, 0, 0, 1);

        run_seg(40, 1, 2, 0, 0, 0);          // fill past depth
        #0.3 check("R10 overflow raised", 64'(overflow), 64'd1);
        run_seg(6, 1, 2, 0, 0, 1);           // stamps show the gap
        run_seg(1, 1, 2, 0, 1, 0);           // rearm
        #0.3 check("R7 rearm stops capture", 64'(capture_on), 64'd0);
        check("R10 overflow cleared", 64'(overflow), 64'd0);
        run_seg(30, 0, 0, 0, 0, 1);
        #0.3 check("R11 drained", 64'(rd_valid), 64'd0);

        run_seg(6, 0, 0, 1, 0, 0);           // second capture, stamp restarts
        run_seg(30, 3, 0, 0, 0, 1);
        run_seg(10, 0, 0, 0, 0, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule